// File: doc/BRIEF.md
# Privileged Flag-Clear Instruction Unit

This unit watches an instruction byte stream, one byte per cycle while `byte_vld` is high, and picks out a three-byte escape opcode that takes no operands and whose only job is to clear the alignment-check bit of the flags word. Legacy prefix bytes may come before the opcode. The unit remembers the ones that change how the sequence is treated and passes over the rest.

When the final opcode byte arrives, the unit samples the processor context: privilege level, operating mode, the access-prevention feature bit and the current flags word. It then produces exactly one outcome. A retire pulse comes with flags that have only the alignment-check bit cleared. A fault pulse means invalid opcode and leaves the flags untouched. A not-matched pulse means the bytes were not this instruction. Any byte that breaks the sequence also produces a not-matched pulse and returns the recognizer to idle.

The recognizer has three states. `ST_IDLE` waits for prefixes or the escape byte. `ST_ESC` has seen the escape byte 0x0F. `ST_GRP` has seen 0x0F followed by 0x01. The transitions are:
- IDLE→IDLE on a prefix byte.
- IDLE→ESC on 0x0F.
- ESC→GRP on 0x01.
- GRP→IDLE on 0xCA, which completes the instruction.
- Break: any other byte returns the machine to IDLE and reports not-matched.
- Hold: a cycle with `byte_vld` low keeps the state.

Top module: `flagclr_unit`

## Requirements
- R1: While reset is asserted, `retire`, `fault` and `nomatch` are 0 and `flags_out` is 0.
- R2: The bytes 0x0F, 0x01, 0xCA in that order, in an allowed context, give a one-cycle `retire` in the cycle after the 0xCA byte is accepted. In that same cycle `flags_out` equals the sampled `flags_in` with bit 18 cleared and every other bit unchanged.
- R3: At most one of `retire`, `fault` and `nomatch` is high in any cycle, and each lasts one cycle.
- R4: If any 0x66, 0xF2 or 0xF3 prefix precedes the opcode, the completed sequence gives `nomatch` in every context, even together with 0xF0. `flags_out` is then unmodified.
- R5: A 0xF0 prefix before the opcode gives `fault` in every mode where the opcode is recognized.
- R6: In mode 1 (protected), mode 3 (compatibility) and mode 4 (64-bit), a `cpl` other than 0 gives `fault`.
- R7: In mode 0 (real-address), `cpl` is ignored. Only a 0xF0 prefix or `feat_en`=0 can cause a fault there.
- R8: In mode 2 (virtual-8086), the completed sequence always gives `fault`.
- R9: With `feat_en`=0, the completed sequence gives `fault` in every mode.
- R10: A byte that breaks the sequence gives `nomatch` one cycle later and returns the unit to idle, so that a correct sequence right after it retires. Breaking bytes are:
  - in idle, a byte that is neither a prefix nor 0x0F;
  - after 0x0F, a byte other than 0x01;
  - after 0x0F 0x01, a byte other than 0xCA.
- R11: On `fault`, `flags_out` equals the sampled `flags_in` unchanged.
- R12: Cycles with `byte_vld` low neither advance the sequence nor produce a pulse.
- R13: The reserved mode codes 5, 6 and 7 give `fault` on a completed sequence.
- R14: The prefixes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65 and 0x67 are accepted in idle and have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | `byte_in` carries a stream byte this cycle |
| byte_in | input | 8 | Instruction stream byte |
| cpl | input | CPL_W | Current privilege level |
| mode | input | 3 | Operating mode: 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit |
| feat_en | input | 1 | Access-prevention feature present |
| flags_in | input | FLAG_W | Current flags word |
| flags_out | output | FLAG_W | Registered flags word, with bit AC_POS cleared after a retire |
| retire | output | 1 | Instruction executed |
| fault | output | 1 | Invalid-opcode fault |
| nomatch | output | 1 | Bytes were not this instruction |

## Verification
On every cycle, the assertions check three things. First, the three outcome pulses are mutually exclusive and only follow a valid byte. Second, a retire clears exactly the alignment-check bit, while a fault or not-matched leaves the flags as sampled. Third, no retire ever follows a virtual-8086 context, a missing feature bit, or a non-zero privilege level in a privilege-checked mode.

Only the bench scenarios can show the rest. These are the full decision over mode, privilege, feature bit and prefix mix, the precedence of the no-prefix rule over the lock rule, recovery after each kind of broken sequence, and the fact that idle gaps leave a partial sequence intact.

// File: rtl/flagclr_pkg.sv
`timescale 1ns/1ps
package flagclr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ESC  = 2'd1,
        ST_GRP  = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        MD_REAL   = 3'd0,
        MD_PROT   = 3'd1,
        MD_V86    = 3'd2,
        MD_COMPAT = 3'd3,
        MD_LONG   = 3'd4
    } cpu_mode_e;

    typedef enum logic [1:0] {
        OUT_NONE    = 2'd0,
        OUT_RETIRE  = 2'd1,
        OUT_FAULT   = 2'd2,
        OUT_NOMATCH = 2'd3
    } outcome_e;

    localparam logic [7:0] OPC_ESC  = 8'h0F;
    localparam logic [7:0] OPC_GRP  = 8'h01;
    localparam logic [7:0] OPC_LAST = 8'hCA;

    localparam logic [7:0] PFX_LOCK = 8'hF0;
    localparam logic [7:0] PFX_OPSZ = 8'h66;
    localparam logic [7:0] PFX_REPN = 8'hF2;
    localparam logic [7:0] PFX_REP  = 8'hF3;

endpackage

// File: rtl/flagclr_pfx_class.sv
`timescale 1ns/1ps
module flagclr_pfx_class
    import flagclr_pkg::*;
(
    input  logic [7:0] byte_in,
    output logic       is_lock,
    output logic       is_np,
    output logic       is_seg
);
    localparam int N_SEG = 7;
    localparam logic [N_SEG*8-1:0] SEG_LIST =
        {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h67};

    logic [N_SEG-1:0] seg_hit;

    for (genvar i = 0; i < N_SEG; i++) begin : g_seg
        assign seg_hit[i] = (byte_in == SEG_LIST[i*8 +: 8]);
    end

    assign is_seg  = |seg_hit;
    assign is_lock = (byte_in == PFX_LOCK);
    assign is_np   = (byte_in == PFX_OPSZ) || (byte_in == PFX_REPN) ||
                     (byte_in == PFX_REP);
endmodule

// File: rtl/flagclr_seq.sv
`timescale 1ns/1ps
module flagclr_seq
    import flagclr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       is_lock,
    input  logic       is_np,
    input  logic       is_seg,
    output logic       done,
    output logic       brk,
    output logic       saw_lock,
    output logic       saw_np
);
    seq_state_e state_q, state_d;

    // next state and completion / break decode
    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        brk     = 1'b0;
        if (byte_vld) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (byte_in == OPC_ESC)
                        state_d = ST_ESC;
                    else if (!(is_lock || is_np || is_seg))
                        brk = 1'b1;
                end
                ST_ESC: begin
                    if (byte_in == OPC_GRP)
                        state_d = ST_GRP;
                    else begin
                        state_d = ST_IDLE;
                        brk     = 1'b1;
                    end
                end
                ST_GRP: begin
                    state_d = ST_IDLE;
                    if (byte_in == OPC_LAST) done = 1'b1;
                    else                     brk  = 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register with prefix memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            saw_lock <= 1'b0;
            saw_np   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (done || brk) begin
                saw_lock <= 1'b0;
                saw_np   <= 1'b0;
            end else if (byte_vld && state_q == ST_IDLE && state_d == ST_IDLE) begin
                saw_lock <= saw_lock | is_lock;
                saw_np   <= saw_np   | is_np;
            end
        end
    end
endmodule

// File: rtl/flagclr_policy.sv
`timescale 1ns/1ps
module flagclr_policy
    import flagclr_pkg::*;
#(
    parameter int CPL_W = 2
) (
    input  logic [2:0]       mode,
    input  logic [CPL_W-1:0] cpl,
    input  logic             feat_en,
    input  logic             saw_lock,
    input  logic             saw_np,
    output outcome_e         verdict
);
    logic priv_mode;
    logic known_mode;

    assign priv_mode  = (mode == MD_PROT) || (mode == MD_COMPAT) || (mode == MD_LONG);
    assign known_mode = priv_mode || (mode == MD_REAL);

    always_comb begin
        if (saw_np)                        verdict = OUT_NOMATCH;
        else if (!known_mode)              verdict = OUT_FAULT;
        else if (!feat_en)                 verdict = OUT_FAULT;
        else if (saw_lock)                 verdict = OUT_FAULT;
        else if (priv_mode && cpl != '0)   verdict = OUT_FAULT;
        else                               verdict = OUT_RETIRE;
    end
endmodule

// File: rtl/flagclr_unit.sv
`timescale 1ns/1ps
module flagclr_unit
    import flagclr_pkg::*;
#(
    parameter int FLAG_W = 32,
    parameter int AC_POS = 18,
    parameter int CPL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic [CPL_W-1:0]  cpl,
    input  logic [2:0]        mode,
    input  logic              feat_en,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out,
    output logic              retire,
    output logic              fault,
    output logic              nomatch
);
    localparam logic [FLAG_W-1:0] AC_MASK = FLAG_W'(1) << AC_POS;

    logic     is_lock, is_np, is_seg;
    logic     done, brk, saw_lock, saw_np;
    outcome_e verdict, outcome;

    flagclr_pfx_class u_pfx (
        .byte_in (byte_in),
        .is_lock (is_lock),
        .is_np   (is_np),
        .is_seg  (is_seg)
    );

    flagclr_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .is_lock  (is_lock),
        .is_np    (is_np),
        .is_seg   (is_seg),
        .done     (done),
        .brk      (brk),
        .saw_lock (saw_lock),
        .saw_np   (saw_np)
    );

    flagclr_policy #(.CPL_W(CPL_W)) u_pol (
        .mode     (mode),
        .cpl      (cpl),
        .feat_en  (feat_en),
        .saw_lock (saw_lock),
        .saw_np   (saw_np),
        .verdict  (verdict)
    );

    always_comb begin
        if (done)     outcome = verdict;
        else if (brk) outcome = OUT_NOMATCH;
        else          outcome = OUT_NONE;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_out <= '0;
            retire    <= 1'b0;
            fault     <= 1'b0;
            nomatch   <= 1'b0;
        end else begin
            retire    <= (outcome == OUT_RETIRE);
            fault     <= (outcome == OUT_FAULT);
            nomatch   <= (outcome == OUT_NOMATCH);
            flags_out <= (outcome == OUT_RETIRE) ? (flags_in & ~AC_MASK) : flags_in;
        end
    end
endmodule

// File: rtl/flagclr_chk.sv
`timescale 1ns/1ps
module flagclr_chk #(
    parameter int FLAG_W = 32,
    parameter int AC_POS = 18,
    parameter int CPL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic [CPL_W-1:0]  cpl,
    input logic [2:0]        mode,
    input logic              feat_en,
    input logic [FLAG_W-1:0] flags_in,
    input logic [FLAG_W-1:0] flags_out,
    input logic              retire,
    input logic              fault,
    input logic              nomatch
);
    localparam logic [FLAG_W-1:0] AC_MASK = FLAG_W'(1) << AC_POS;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retire, fault, nomatch})); // R3
    AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire); // R3
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_vld) |-> !(retire || fault || nomatch)); // R12
    AST_RETIRE_AC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (flags_out == ($past(flags_in) & ~AC_MASK))); // R2
    AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (flags_out == $past(flags_in))); // R11
    AST_NOMATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch |-> (flags_out == $past(flags_in))); // R4
    AST_NO_V86_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> ($past(mode) != 3'd2)); // R8
    AST_FEAT_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> $past(feat_en)); // R9
    AST_PRIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && ($past(mode) == 3'd1 || $past(mode) == 3'd3 || $past(mode) == 3'd4))
        |-> ($past(cpl) == '0)); // R6
    AST_RSVD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> ($past(mode) <= 3'd4)); // R13
endmodule

bind flagclr_unit flagclr_chk #(.FLAG_W(FLAG_W), .AC_POS(AC_POS), .CPL_W(CPL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .cpl       (cpl),
    .mode      (mode),
    .feat_en   (feat_en),
    .flags_in  (flags_in),
    .flags_out (flags_out),
    .retire    (retire),
    .fault     (fault),
    .nomatch   (nomatch)
);

// File: tb/flagclr_unit_bench.sv
`timescale 1ns/1ps
module flagclr_unit_bench;
    localparam int FW = 32;
    localparam logic [FW-1:0] ACM = 32'h0004_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_in = 8'h00;
    logic [1:0]    cpl = 2'd0;
    logic [2:0]    mode = 3'd0;
    logic          feat_en = 1'b1;
    logic [FW-1:0] flags_in = '0;
    logic [FW-1:0] flags_out;
    logic          retire, fault, nomatch;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    flagclr_unit u_flagclr_unit (
        .clk (clk), .rst_n (rst_n), .byte_vld (byte_vld), .byte_in (byte_in),
        .cpl (cpl), .mode (mode), .feat_en (feat_en), .flags_in (flags_in),
        .flags_out (flags_out), .retire (retire), .fault (fault), .nomatch (nomatch)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !ended) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    // kind: 0 none, 1 retire, 2 fault, 3 nomatch
    task automatic check(string req, int kind, logic [FW-1:0] fexp);
        logic [2:0] exp_p;
        exp_p = {kind == 1, kind == 2, kind == 3};
        n_cmp++;
        if ({retire, fault, nomatch} !== exp_p || flags_out !== fexp) begin
            n_bad++;
            $display("FAIL %s: actual r/f/n=%b flags=%h expected r/f/n=%b flags=%h",
                     req, {retire, fault, nomatch}, flags_out, exp_p, fexp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        byte_vld = 1'b1;
        byte_in  = b;
        @(posedge clk);
        #1;
        byte_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        flags_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1", 0, '0);
        rst_n = 1'b1;
        gap(1);

        // full sweep of context and prefix mix
        for (int m = 0; m < 8; m++)
            for (int c = 0; c < 4; c++)
                for (int fe = 0; fe < 2; fe++)
                    for (int pc = 0; pc < 8; pc++) begin
                        int    idx;
                        bit    lk, np;
                        int    kind;
                        string req;
                        idx      = ((m * 4 + c) * 2 + fe) * 8 + pc;
                        mode     = 3'(m);
                        cpl      = 2'(c);
                        feat_en  = fe[0];
                        flags_in = (32'(idx) * 32'h9E37_79B1) | ACM;
                        if (idx % 5 == 0) flags_in = flags_in & ~ACM;
                        lk = (pc == 1 || pc == 6 || pc == 7);
                        np = (pc >= 2 && pc <= 4) || pc == 7;
                        case (pc)
                            1: push(8'hF0);
                            2: push(8'h66);
                            3: push(8'hF2);
                            4: push(8'hF3);
                            5: push(8'h2E);
                            6: begin push(8'hF0); push(8'h65); end
                            7: begin push(8'hF0); push(8'h66); end
                            default: ;
                        endcase
                        push(8'h0F);
                        push(8'h01);
                        push(8'hCA);
                        if (np)                        begin kind = 3; req = "R4"; end
                        else if (m == 2)               begin kind = 2; req = "R8,R11"; end
                        else if (m > 4)                begin kind = 2; req = "R13,R11"; end
                        else if (fe == 0)              begin kind = 2; req = "R9,R11"; end
                        else if (lk)                   begin kind = 2; req = "R5,R11"; end
                        else if (m != 0 && c != 0)     begin kind = 2; req = "R6,R11"; end
                        else if (pc == 5)              begin kind = 1; req = "R14"; end
                        else if (m == 0)               begin kind = 1; req = "R7"; end
                        else                           begin kind = 1; req = "R2"; end
                        check(req, kind, (kind == 1) ? (flags_in & ~ACM) : flags_in);
                    end

        // broken sequences and recovery
        mode = 3'd4; cpl = 2'd0; feat_en = 1'b1; flags_in = 32'h1234_5678 | ACM;
        push(8'h90);
        check("R10", 3, flags_in);
        push(8'h0F); push(8'h02);
        check("R10", 3, flags_in);
        push(8'h0F); push(8'h01); push(8'hCB);
        check("R10", 3, flags_in);
        push(8'h0F); push(8'h0F);
        check("R10", 3, flags_in);
        push(8'h0F); push(8'h01); push(8'hCA);
        check("R10", 1, flags_in & ~ACM);

        // idle gaps inside a sequence
        push(8'h0F);
        gap(1);
        check("R12", 0, flags_in);
        gap(2);
        push(8'h01);
        gap(3);
        check("R12", 0, flags_in);
        push(8'hCA);
        check("R12", 1, flags_in & ~ACM);
        gap(1);
        check("R3", 0, flags_in);

        finish_run();
    end
endmodule